// File: doc/BRIEF.md
# Tamper Status and Security Controller

This block collects tamper alarms and counter-overflow indications from a secure always-on domain. It keeps each alarm in a sticky detect bit and compares it against a per-source enable. An enabled alarm drives the unit into a security-violation state. In the same cycle the block marks the kept time as not valid and forces the time counter's enable off. Software reads the status over a simple register port and clears the detect bits by writing ones to them. The two security flags can only be cleared in a fixed order: detect bits first, then the violation flag, then the not-valid flag.

A control register holds the counter enable and five lock bits in two persistence classes. Soft locks are removed by the main-reset input. Hard locks are removed only by the battery-reset input, which restores the whole block. Locks stop software from re-enabling a stopped counter, from clearing detect bits, or from leaving the failure state. A security interrupt is raised while the violation flag is set and its enable is on.

Top module: `tamper_sec_ctrl`

## Requirements
- R1: After battery reset every register reads zero, except status bit 1 (not-valid), which reads 1. The counter enable output and the interrupt are low.
- R2: An alarm pulse on source i latches status bit 16+i. Sources are ordered voltage, clock, temperature, security alarm, external boot, external A, external B, wire mesh. A timer-overflow pulse latches status bit 2 and a monotonic-overflow pulse latches status bit 3. Each of these latches whether or not its enable is set.
- R3: An alarm whose enable is set causes three things at the next edge: status bit 0 (violation) and bit 1 (not-valid) set, and control bit 3 (counter enable) clears. The enables sit in the tamper-enable register: bits 0..7 per source, bit 8 for timer overflow, bit 9 for monotonic overflow. In the cycle the alarm is present, cnt_clr_o is high.
- R4: Writing 1 to a detect bit in the status register clears it. A new alarm in the same cycle takes priority and keeps it set.
- R5: A write that clears the violation flag is refused in two cases: any detect bit (16..23, 2, 3) was set before the write, or the failure hard lock (control bit 16) is set.
- R6: A write that clears the not-valid flag is refused while the violation flag was set before the write.
- R7: While the detect-clear soft lock (control bit 29) or hard lock (control bit 30) is set, writes that clear detect bits are refused.
- R8: A write of 1 to the counter enable is refused while the enable is 0 and the time soft lock (bit 17) or time hard lock (bit 18) is set. It is also refused while the violation flag is set. Writing 0 always clears the enable.
- R9: A lock bit is set by writing 1, and writing 0 does not clear it. Main reset clears bits 17 and 29 only. Battery reset clears all of them.
- R10: sec_irq_o is high exactly when the violation flag and interrupt-enable bit 0 are both set.
- R11: Read address 0 returns the control register, 1 the status, 2 the interrupt enable and 3 the tamper enables. status_o mirrors the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| batt_rst | input | 1 | Battery-domain synchronous reset, active high; restores everything |
| main_rst | input | 1 | Main-power reset, active high; clears soft locks only |
| evt_i | input | 8 | Tamper alarm pulses, one per source |
| tmr_ovf_i | input | 1 | Time counter overflow pulse |
| mono_ovf_i | input | 1 | Monotonic counter overflow pulse |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| status_o | output | 32 | Status register |
| sec_irq_o | output | 1 | Security violation interrupt |
| cnt_clr_o | output | 1 | Forces the time counter enable off |
| cnt_en_o | output | 1 | Time counter enable |

## Verification
The hardest situation to reach is a write that arrives while the block is already in a locked or violated state. Examples are trying to clear the violation flag in the same write that clears the last detect bit, or re-enabling the counter under a hard lock that survives main reset. The stimulus first builds the state step by step: it enables a source, fires its alarm and sets lock bits. Only then does it issue the refused writes, reading the register back after each one. Main-reset and battery-reset pulses then show which locks persist.

// File: rtl/tsec_pkg.sv
package tsec_pkg;
    localparam int TSEC_DATA_W  = 32;
    localparam int TSEC_NUM_SRC = 8;
    localparam int TSEC_ADDR_W  = 2;

    // status register bit positions
    localparam int ST_SV       = 0;
    localparam int ST_NV       = 1;
    localparam int ST_TOVF     = 2;
    localparam int ST_MOVF     = 3;
    localparam int ST_SRC_BASE = 16;

    // control register bit positions
    localparam int CT_TCE = 3;
    localparam int CT_FHL = 16;
    localparam int CT_TSL = 17;
    localparam int CT_THL = 18;
    localparam int CT_DSL = 29;
    localparam int CT_DHL = 30;

    typedef enum logic [TSEC_ADDR_W-1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_IEN  = 2'd2,
        RA_TEN  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic tce;
        logic fail_hl;
        logic time_sl;
        logic time_hl;
        logic dclr_sl;
        logic dclr_hl;
    } ctrl_t;

    // sticky bit with write-1-to-clear; a new set wins over a clear
    function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

    function automatic logic [TSEC_DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [TSEC_DATA_W-1:0] w;
        w = '0;
        w[CT_TCE] = c.tce;
        w[CT_FHL] = c.fail_hl;
        w[CT_TSL] = c.time_sl;
        w[CT_THL] = c.time_hl;
        w[CT_DSL] = c.dclr_sl;
        w[CT_DHL] = c.dclr_hl;
        return w;
    endfunction
endpackage

// File: rtl/tsec_status.sv
module tsec_status
    import tsec_pkg::*;
#(
    parameter int NUM_SRC = TSEC_NUM_SRC,
    parameter int DATA_W  = TSEC_DATA_W
) (
    input  logic               clk,
    input  logic               batt_rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               tmr_ovf_i,
    input  logic               mono_ovf_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               tmr_en_i,
    input  logic               mono_en_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               fail_lock_i,
    input  logic               clr_lock_i,
    output logic [DATA_W-1:0]  stat_o,
    output logic               trig_o
);
    logic [NUM_SRC-1:0] src_det;
    logic               tmr_det;
    logic               mono_det;
    logic               sv_q;
    logic               nv_q;
    logic               any_det;
    logic               det_clr_ok;

    assign any_det    = (|src_det) | tmr_det | mono_det;
    assign det_clr_ok = wr_i & ~clr_lock_i;
    assign trig_o     = (|(evt_i & src_en_i)) | (tmr_ovf_i & tmr_en_i) | (mono_ovf_i & mono_en_i);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            always_ff @(posedge clk) begin
                if (batt_rst) src_det[i] <= 1'b0;
                else          src_det[i] <= w1c_next(src_det[i], evt_i[i],
                                                     det_clr_ok & wdata_i[ST_SRC_BASE+i]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (batt_rst) begin
            tmr_det  <= 1'b0;
            mono_det <= 1'b0;
        end else begin
            tmr_det  <= w1c_next(tmr_det, tmr_ovf_i, det_clr_ok & wdata_i[ST_TOVF]);
            mono_det <= w1c_next(mono_det, mono_ovf_i, det_clr_ok & wdata_i[ST_MOVF]);
        end
    end

    // security flags: set by an enabled alarm, cleared only in order
    always_ff @(posedge clk) begin
        if (batt_rst) begin
            sv_q <= 1'b0;
            nv_q <= 1'b1;
        end else if (trig_o) begin
            sv_q <= 1'b1;
            nv_q <= 1'b1;
        end else if (wr_i) begin
            if (wdata_i[ST_SV] && !any_det && !fail_lock_i) sv_q <= 1'b0;
            if (wdata_i[ST_NV] && !sv_q)                    nv_q <= 1'b0;
        end
    end

    always_comb begin
        stat_o                            = '0;
        stat_o[ST_SV]                     = sv_q;
        stat_o[ST_NV]                     = nv_q;
        stat_o[ST_TOVF]                   = tmr_det;
        stat_o[ST_MOVF]                   = mono_det;
        stat_o[ST_SRC_BASE +: NUM_SRC]    = src_det;
    end
endmodule

// File: rtl/tsec_ctrl.sv
module tsec_ctrl
    import tsec_pkg::*;
#(
    parameter int DATA_W = TSEC_DATA_W
) (
    input  logic              clk,
    input  logic              batt_rst,
    input  logic              main_rst,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              trig_i,
    input  logic              sv_i,
    output ctrl_t             ctrl_o
);
    ctrl_t cur_q;
    ctrl_t nxt;
    logic  time_lock;

    assign time_lock = cur_q.time_sl | cur_q.time_hl;

    always_comb begin
        nxt = cur_q;
        if (main_rst) begin
            nxt.time_sl = 1'b0;
            nxt.dclr_sl = 1'b0;
        end
        if (wr_i) begin
            nxt.fail_hl = nxt.fail_hl | wdata_i[CT_FHL];
            nxt.time_sl = nxt.time_sl | wdata_i[CT_TSL];
            nxt.time_hl = nxt.time_hl | wdata_i[CT_THL];
            nxt.dclr_sl = nxt.dclr_sl | wdata_i[CT_DSL];
            nxt.dclr_hl = nxt.dclr_hl | wdata_i[CT_DHL];
            if (wdata_i[CT_TCE]) nxt.tce = cur_q.tce | (~time_lock & ~sv_i);
            else                 nxt.tce = 1'b0;
        end
        if (trig_i) nxt.tce = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (batt_rst) cur_q <= '0;
        else          cur_q <= nxt;
    end

    assign ctrl_o = cur_q;
endmodule

// File: rtl/tsec_cfg.sv
module tsec_cfg
    import tsec_pkg::*;
#(
    parameter int NUM_SRC = TSEC_NUM_SRC,
    parameter int DATA_W  = TSEC_DATA_W
) (
    input  logic               clk,
    input  logic               batt_rst,
    input  logic               wr_ien_i,
    input  logic               wr_ten_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic               ien_sv_o,
    output logic [NUM_SRC-1:0] src_en_o,
    output logic               tmr_en_o,
    output logic               mono_en_o
);
    localparam int TEN_TMR  = NUM_SRC;
    localparam int TEN_MONO = NUM_SRC + 1;
    localparam int TEN_W    = NUM_SRC + 2;

    logic [TEN_W-1:0] ten_q;
    logic             ien_q;

    always_ff @(posedge clk) begin
        if (batt_rst) begin
            ten_q <= '0;
            ien_q <= 1'b0;
        end else begin
            if (wr_ten_i) ten_q <= wdata_i[TEN_W-1:0];
            if (wr_ien_i) ien_q <= wdata_i[0];
        end
    end

    assign ien_sv_o  = ien_q;
    assign src_en_o  = ten_q[NUM_SRC-1:0];
    assign tmr_en_o  = ten_q[TEN_TMR];
    assign mono_en_o = ten_q[TEN_MONO];
endmodule

// File: rtl/tamper_sec_ctrl.sv
module tamper_sec_ctrl
    import tsec_pkg::*;
#(
    parameter int NUM_SRC = TSEC_NUM_SRC,
    parameter int DATA_W  = TSEC_DATA_W
) (
    input  logic                   clk,
    input  logic                   batt_rst,
    input  logic                   main_rst,
    input  logic [NUM_SRC-1:0]     evt_i,
    input  logic                   tmr_ovf_i,
    input  logic                   mono_ovf_i,
    input  logic                   bus_we,
    input  logic [TSEC_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [DATA_W-1:0]      status_o,
    output logic                   sec_irq_o,
    output logic                   cnt_clr_o,
    output logic                   cnt_en_o
);
    localparam int TEN_W = NUM_SRC + 2;

    reg_addr_e          sel;
    logic               wr_ctrl, wr_stat, wr_ien, wr_ten;
    ctrl_t              ctrl_s;
    logic [DATA_W-1:0]  ctrl_w;
    logic               trig;
    logic               ien_sv;
    logic [NUM_SRC-1:0] src_en;
    logic               tmr_en, mono_en;

    assign sel     = reg_addr_e'(bus_addr);
    assign wr_ctrl = bus_we && (sel == RA_CTRL);
    assign wr_stat = bus_we && (sel == RA_STAT);
    assign wr_ien  = bus_we && (sel == RA_IEN);
    assign wr_ten  = bus_we && (sel == RA_TEN);

    tsec_status #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_status (
        .clk         (clk),
        .batt_rst    (batt_rst),
        .evt_i       (evt_i),
        .tmr_ovf_i   (tmr_ovf_i),
        .mono_ovf_i  (mono_ovf_i),
        .src_en_i    (src_en),
        .tmr_en_i    (tmr_en),
        .mono_en_i   (mono_en),
        .wr_i        (wr_stat),
        .wdata_i     (bus_wdata),
        .fail_lock_i (ctrl_s.fail_hl),
        .clr_lock_i  (ctrl_s.dclr_sl | ctrl_s.dclr_hl),
        .stat_o      (status_o),
        .trig_o      (trig)
    );

    tsec_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .batt_rst (batt_rst),
        .main_rst (main_rst),
        .wr_i     (wr_ctrl),
        .wdata_i  (bus_wdata),
        .trig_i   (trig),
        .sv_i     (status_o[ST_SV]),
        .ctrl_o   (ctrl_s)
    );

    tsec_cfg #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .batt_rst  (batt_rst),
        .wr_ien_i  (wr_ien),
        .wr_ten_i  (wr_ten),
        .wdata_i   (bus_wdata),
        .ien_sv_o  (ien_sv),
        .src_en_o  (src_en),
        .tmr_en_o  (tmr_en),
        .mono_en_o (mono_en)
    );

    assign ctrl_w    = pack_ctrl(ctrl_s);
    assign cnt_clr_o = trig;
    assign cnt_en_o  = ctrl_s.tce;
    assign sec_irq_o = status_o[ST_SV] & ien_sv;

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            RA_CTRL: bus_rdata = ctrl_w;
            RA_STAT: bus_rdata = status_o;
            RA_IEN:  bus_rdata[0] = ien_sv;
            RA_TEN:  bus_rdata[TEN_W-1:0] = {mono_en, tmr_en, src_en};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsec_chk.sv
module tsec_chk
    import tsec_pkg::*;
#(
    parameter int NUM_SRC = TSEC_NUM_SRC,
    parameter int DATA_W  = TSEC_DATA_W
) (
    input logic               clk,
    input logic               batt_rst,
    input logic               main_rst,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [DATA_W-1:0]  status_o,
    input logic [DATA_W-1:0]  ctrl_w,
    input logic               sec_irq_o,
    input logic               cnt_clr_o,
    input logic               cnt_en_o
);
    logic any_det;
    assign any_det = (|status_o[ST_SRC_BASE +: NUM_SRC]) | status_o[ST_TOVF] | status_o[ST_MOVF];

    p_latch_r2: assert property (@(posedge clk) disable iff (batt_rst)
        (|evt_i) |=> ((status_o[ST_SRC_BASE +: NUM_SRC] & $past(evt_i)) == $past(evt_i)));

    p_sv_implies_nv_r3: assert property (@(posedge clk) disable iff (batt_rst)
        status_o[ST_SV] |-> status_o[ST_NV]);

    p_trig_stops_cnt_r3: assert property (@(posedge clk) disable iff (batt_rst)
        cnt_clr_o |=> (!cnt_en_o && status_o[ST_SV]));

    p_sv_clear_order_r5: assert property (@(posedge clk) disable iff (batt_rst)
        ($fell(status_o[ST_SV]) && !$past(batt_rst)) |-> (!$past(any_det) && !$past(ctrl_w[CT_FHL])));

    p_nv_clear_order_r6: assert property (@(posedge clk) disable iff (batt_rst)
        $fell(status_o[ST_NV]) |-> !$past(status_o[ST_SV]));

    p_tce_locked_r8: assert property (@(posedge clk) disable iff (batt_rst)
        (!cnt_en_o && (ctrl_w[CT_TSL] || ctrl_w[CT_THL])) |=> !cnt_en_o);

    p_hard_lock_sticky_r9: assert property (@(posedge clk) disable iff (batt_rst)
        ctrl_w[CT_THL] |=> ctrl_w[CT_THL]);

    p_soft_lock_sticky_r9: assert property (@(posedge clk) disable iff (batt_rst)
        (ctrl_w[CT_DSL] && !main_rst) |=> ctrl_w[CT_DSL]);

    p_irq_needs_sv_r10: assert property (@(posedge clk) disable iff (batt_rst)
        sec_irq_o |-> status_o[ST_SV]);
endmodule

bind tamper_sec_ctrl tsec_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .batt_rst  (batt_rst),
    .main_rst  (main_rst),
    .evt_i     (evt_i),
    .status_o  (status_o),
    .ctrl_w    (ctrl_w),
    .sec_irq_o (sec_irq_o),
    .cnt_clr_o (cnt_clr_o),
    .cnt_en_o  (cnt_en_o)
);

// File: tb/tb_tamper_sec_ctrl.sv
`timescale 1ns/1ps
module tb_tamper_sec_ctrl;
    localparam int KIND_RD  = 0;
    localparam int KIND_IRQ = 1;
    localparam int KIND_CLR = 2;
    localparam int KIND_EN  = 3;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_IEN  = 2'd2;
    localparam logic [1:0] A_TEN  = 2'd3;

    logic        clk = 1'b0;
    logic        batt_rst = 1'b1;
    logic        main_rst = 1'b1;
    logic [7:0]  evt_i = '0;
    logic        tmr_ovf_i = 1'b0;
    logic        mono_ovf_i = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] status_o;
    logic        sec_irq_o;
    logic        cnt_clr_o;
    logic        cnt_en_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    tamper_sec_ctrl dut (
        .clk(clk), .batt_rst(batt_rst), .main_rst(main_rst),
        .evt_i(evt_i), .tmr_ovf_i(tmr_ovf_i), .mono_ovf_i(mono_ovf_i),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .status_o(status_o), .sec_irq_o(sec_irq_o),
        .cnt_clr_o(cnt_clr_o), .cnt_en_o(cnt_en_o)
    );

    // monitor: compare each queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                KIND_RD:  act = bus_rdata;
                KIND_IRQ: act = {31'd0, sec_irq_o};
                KIND_CLR: act = {31'd0, cnt_clr_o};
                default:  act = {31'd0, cnt_en_o};
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        push(KIND_RD, exp, tag);
        @(negedge clk); #1;
    endtask

    task automatic exp_sig(input int kind, input logic exp, input string tag);
        @(posedge clk); #1;
        push(kind, {31'd0, exp}, tag);
        @(negedge clk); #1;
    endtask

    task automatic wr_evt(input logic [1:0] a, input logic [31:0] d, input logic [7:0] ev);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; evt_i = ev;
        @(posedge clk); #1;
        bus_we = 1'b0; evt_i = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_evt(a, d, 8'h00);
    endtask

    task automatic pulse(input logic [7:0] ev, input logic t, input logic m,
                         input logic exp_clr, input string tag);
        @(posedge clk); #1;
        evt_i = ev; tmr_ovf_i = t; mono_ovf_i = m;
        push(KIND_CLR, {31'd0, exp_clr}, tag);
        @(posedge clk); #1;
        evt_i = '0; tmr_ovf_i = 1'b0; mono_ovf_i = 1'b0;
    endtask

    task automatic pulse_rst(input bit batt);
        @(posedge clk); #1;
        if (batt) batt_rst = 1'b1; else main_rst = 1'b1;
        @(posedge clk); #1;
        batt_rst = 1'b0; main_rst = 1'b0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; batt_rst = 1'b0; main_rst = 1'b0;

        // R1 reset state
        exp_rd(A_STAT, 32'h2, "R1 status after battery reset");
        exp_rd(A_CTRL, 32'h0, "R1 control after battery reset");
        exp_sig(KIND_EN, 1'b0, "R1 counter enable low");
        exp_sig(KIND_IRQ, 1'b0, "R10 irq low after reset");

        wr(A_STAT, 32'h2);
        exp_rd(A_STAT, 32'h0, "R6 not-valid clears with violation clear");
        wr(A_CTRL, 32'h8);
        exp_rd(A_CTRL, 32'h8, "R8 counter enable set when unlocked");
        exp_sig(KIND_EN, 1'b1, "R8 counter enable output");

        // R2 masked alarm latches only
        wr(A_TEN, 32'h0);
        pulse(8'h01, 1'b0, 1'b0, 1'b0, "R3 masked alarm no clear");
        exp_rd(A_STAT, 32'h0001_0000, "R2 voltage alarm latched, no violation");
        exp_sig(KIND_EN, 1'b1, "R3 masked alarm keeps counter");
        wr(A_STAT, 32'h0001_0000);
        exp_rd(A_STAT, 32'h0, "R4 detect bit write-1-clear");

        // R11 config readback
        wr(A_TEN, 32'h3FF);
        exp_rd(A_TEN, 32'h3FF, "R11 tamper enable readback");
        wr(A_IEN, 32'h1);
        exp_rd(A_IEN, 32'h1, "R11 interrupt enable readback");

        // R3 enabled alarm
        pulse(8'h20, 1'b0, 1'b0, 1'b1, "R3 enabled alarm clear pulse");
        exp_rd(A_STAT, 32'h0020_0003, "R3 external A sets violation and not-valid");
        exp_sig(KIND_EN, 1'b0, "R3 counter enable forced off");
        exp_sig(KIND_IRQ, 1'b1, "R10 irq with violation");

        wr(A_STAT, 32'h1);
        exp_rd(A_STAT, 32'h0020_0003, "R5 violation clear refused with detect set");
        wr(A_STAT, 32'h2);
        exp_rd(A_STAT, 32'h0020_0003, "R6 not-valid clear refused with violation");
        wr(A_CTRL, 32'h8);
        exp_rd(A_CTRL, 32'h0, "R8 enable refused during violation");
        wr(A_STAT, 32'h0020_0001);
        exp_rd(A_STAT, 32'h3, "R5 combined write clears detect only");
        wr(A_STAT, 32'h1);
        exp_rd(A_STAT, 32'h2, "R5 violation clears after detects");
        exp_sig(KIND_IRQ, 1'b0, "R10 irq drops");
        wr(A_STAT, 32'h2);
        exp_rd(A_STAT, 32'h0, "R6 not-valid clears last");

        // overflow sources
        pulse(8'h00, 1'b1, 1'b0, 1'b1, "R3 timer overflow enabled");
        exp_rd(A_STAT, 32'h7, "R2 timer overflow bit 2 with violation");
        wr(A_STAT, 32'h4); wr(A_STAT, 32'h1); wr(A_STAT, 32'h2);
        exp_rd(A_STAT, 32'h0, "R4 ordered clear of overflow");
        wr(A_TEN, 32'hFF);
        pulse(8'h00, 1'b0, 1'b1, 1'b0, "R3 monotonic overflow masked");
        exp_rd(A_STAT, 32'h8, "R2 monotonic overflow bit 3");
        wr(A_STAT, 32'h8);
        exp_rd(A_STAT, 32'h0, "R4 monotonic detect cleared");

        // R7 detect-clear soft lock
        wr(A_CTRL, 32'h2000_0008);
        exp_rd(A_CTRL, 32'h2000_0008, "R9 soft detect-clear lock set");
        wr(A_TEN, 32'h0);
        pulse(8'h80, 1'b0, 1'b0, 1'b0, "R3 masked wire mesh");
        exp_rd(A_STAT, 32'h0080_0000, "R2 wire mesh bit 23");
        wr(A_STAT, 32'h0080_0000);
        exp_rd(A_STAT, 32'h0080_0000, "R7 detect clear refused under lock");
        pulse_rst(1'b0);
        exp_rd(A_CTRL, 32'h8, "R9 main reset drops soft lock");
        wr(A_STAT, 32'h0080_0000);
        exp_rd(A_STAT, 32'h0, "R7 detect clear after unlock");

        // R8/R9 time soft lock
        wr(A_CTRL, 32'h0002_0000);
        exp_rd(A_CTRL, 32'h0002_0000, "R9 time soft lock set, enable cleared");
        wr(A_CTRL, 32'h8);
        exp_rd(A_CTRL, 32'h0002_0000, "R8 enable refused under time lock");
        wr(A_CTRL, 32'h0);
        exp_rd(A_CTRL, 32'h0002_0000, "R9 write 0 keeps lock");
        pulse_rst(1'b0);
        exp_rd(A_CTRL, 32'h0, "R9 main reset drops time soft lock");
        wr(A_CTRL, 32'h8);
        exp_rd(A_CTRL, 32'h8, "R8 enable accepted after unlock");

        // hard locks
        wr(A_CTRL, 32'h4004_0008);
        exp_rd(A_CTRL, 32'h4004_0008, "R9 hard locks set");
        pulse_rst(1'b0);
        exp_rd(A_CTRL, 32'h4004_0008, "R9 hard locks survive main reset");
        wr(A_CTRL, 32'h0);
        exp_rd(A_CTRL, 32'h4004_0000, "R8 enable clears by write 0");
        wr(A_CTRL, 32'h8);
        exp_rd(A_CTRL, 32'h4004_0000, "R8 enable refused under hard lock");

        pulse_rst(1'b1);
        exp_rd(A_STAT, 32'h2, "R1 status after second battery reset");
        exp_rd(A_CTRL, 32'h0, "R9 battery reset drops hard locks");

        // R4 set wins over same-cycle clear
        wr(A_STAT, 32'h2);
        wr_evt(A_STAT, 32'h0002_0000, 8'h02);
        exp_rd(A_STAT, 32'h0002_0000, "R4 new alarm beats clear");
        wr(A_STAT, 32'h0002_0000);
        exp_rd(A_STAT, 32'h0, "R4 clock detect cleared");

        // R5 failure hard lock
        wr(A_CTRL, 32'h0001_0000);
        wr(A_TEN, 32'h1);
        pulse(8'h01, 1'b0, 1'b0, 1'b1, "R3 voltage alarm enabled");
        exp_rd(A_STAT, 32'h0001_0003, "R3 violation with failure lock");
        exp_sig(KIND_IRQ, 1'b0, "R10 irq masked by enable");
        wr(A_STAT, 32'h0001_0000);
        exp_rd(A_STAT, 32'h3, "R4 detect cleared");
        wr(A_STAT, 32'h1);
        exp_rd(A_STAT, 32'h3, "R5 violation held by failure lock");
        exp_rd(A_STAT, status_o, "R11 status_o mirrors status read");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule